// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller handles the refill of a single cache line once a miss has been found. It takes the line index, the tag and the offset of the missing word. It invalidates the target line, then issues one read request to memory. The memory returns the line one word per accepted beat. The first word returned is the requested one. The rest follow in ascending order and wrap past the end of the line back to word 0.

Each accepted word goes into the cache data array in the cycle it arrives. The first word also goes straight to the processor on a separate return port. The processor's stall ends in that same cycle, and the rest of the line keeps loading in the background. The tag is written with its valid flag set only after the whole line is in the array. A lookup therefore never hits a partially loaded line.

While a fill is in progress the controller reports busy and does not accept a new miss. The requester must hold that miss until the current fill completes.

Top module: `cwf_refill`

## Requirements
- R1: After reset the controller is idle: busy, mem_req_valid, rd_ready, arr_we, cpu_valid, cpu_stall and tag_we are all 0.
- R2: miss_ack is 1 exactly when miss_req is 1 and the controller is idle. A miss raised while busy stays unacknowledged until the fill has finished.
- R3: In the cycle a miss is acknowledged, tag_we is 1 and tag_valid is 0, with tag_idx equal to miss_idx. This invalidates the target line before any of its words is overwritten.
- R4: From the cycle after acknowledgement, mem_req_valid is 1 with the latched index, tag and start offset. It stays 1 until mem_req_ready is sampled 1.
- R5: The first beat is written at offset miss_ofs. Each later beat is written at the previous offset plus one, and offset 7 is followed by offset 0, so each of the 8 offsets is written once.
- R6: rd_ready is 1 only while words are being collected. Each accepted beat (rd_valid and rd_ready both 1) produces arr_we=1 in the same cycle, with arr_idx equal to the line index and arr_data equal to rd_data.
- R7: On the first accepted beat of a fill, cpu_valid is 1 for that one cycle and cpu_data equals rd_data. cpu_valid is 0 on every other beat.
- R8: cpu_stall is 1 from the cycle after acknowledgement until the first word arrives. It is 0 in the cycle that word is delivered and afterwards.
- R9: The cycle after the 8th accepted beat has tag_we=1, tag_valid=1, tag_idx equal to the line index and tag_data equal to the miss tag. busy is 1 up to and including that cycle and 0 in the next.
- R10: Cycles with rd_valid=0, and beats offered before the read request is accepted, write nothing and do not advance the word offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | A miss is waiting for service |
| miss_idx | input | IDX_W | Line index of the miss |
| miss_tag | input | TAG_W | Tag of the missing line |
| miss_ofs | input | OFS_W | Word offset that missed |
| miss_ack | output | 1 | Miss accepted this cycle |
| busy | output | 1 | A fill is in progress |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_idx | output | IDX_W | Requested line index |
| mem_req_tag | output | TAG_W | Requested line tag |
| mem_req_ofs | output | OFS_W | Word with which the burst starts |
| rd_valid | input | 1 | Memory word valid |
| rd_ready | output | 1 | Controller takes memory words |
| rd_data | input | DATA_W | Memory word |
| cpu_valid | output | 1 | Forwarded word valid |
| cpu_data | output | DATA_W | Forwarded word |
| cpu_stall | output | 1 | Processor waits for its word |
| arr_we | output | 1 | Data array write enable |
| arr_idx | output | IDX_W | Data array line index |
| arr_ofs | output | OFS_W | Data array word offset |
| arr_data | output | DATA_W | Data array write data |
| tag_we | output | 1 | Tag array write enable |
| tag_valid | output | 1 | Valid flag written with the tag |
| tag_idx | output | IDX_W | Tag array line index |
| tag_data | output | TAG_W | Tag written |

## Verification
The assertions check the following on every cycle:
- acknowledgement only ever starts a fill;
- array writes and stalls happen only while busy;
- consecutive writes step the offset by one with wrap;
- the first write lands on the latched miss offset;
- forwarding ends the stall;
- the tag is validated only directly after a write and after exactly eight writes since the invalidation.

Only the bench's scenarios can show the rest:
- the data values, which need a model of the memory contents;
- a request held across several unready cycles;
- stray beats before the request is taken;
- gaps between beats;
- a second miss held pending for a whole fill.

The bench covers every start offset with three timing patterns.

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  localparam int OFS_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [IDX_W-1:0]  miss_idx,
  input  logic [TAG_W-1:0]  miss_tag,
  input  logic [OFS_W-1:0]  miss_ofs,
  output logic              miss_ack,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [IDX_W-1:0]  mem_req_idx,
  output logic [TAG_W-1:0]  mem_req_tag,
  output logic [OFS_W-1:0]  mem_req_ofs,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cpu_valid,
  output logic [DATA_W-1:0] cpu_data,
  output logic              cpu_stall,
  output logic              arr_we,
  output logic [IDX_W-1:0]  arr_idx,
  output logic [OFS_W-1:0]  arr_ofs,
  output logic [DATA_W-1:0] arr_data,
  output logic              tag_we,
  output logic              tag_valid,
  output logic [IDX_W-1:0]  tag_idx,
  output logic [TAG_W-1:0]  tag_data
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL, S_DONE} state_t;

  state_t             state;
  logic [IDX_W-1:0]   line_idx;
  logic [TAG_W-1:0]   line_tag;
  logic [OFS_W-1:0]   start_ofs;
  logic [OFS_W-1:0]   cur_ofs;
  logic [CNT_W-1:0]   beats;
  logic               first_pend;
  logic               take;
  logic               last;

  assign busy          = state != S_IDLE;
  assign miss_ack      = miss_req && !busy;
  assign mem_req_valid = state == S_REQ;
  assign mem_req_idx   = line_idx;
  assign mem_req_tag   = line_tag;
  assign mem_req_ofs   = start_ofs;
  assign rd_ready      = state == S_FILL;
  assign take          = rd_valid && rd_ready;
  assign last          = take && (beats == CNT_W'(WORDS - 1));

  assign arr_we    = take;
  assign arr_idx   = line_idx;
  assign arr_ofs   = cur_ofs;
  assign arr_data  = rd_data;
  assign cpu_valid = take && first_pend;
  assign cpu_data  = rd_data;
  assign cpu_stall = first_pend && !take;

  assign tag_we    = miss_ack || state == S_DONE;
  assign tag_valid = state == S_DONE;
  assign tag_idx   = busy ? line_idx : miss_idx;
  assign tag_data  = busy ? line_tag : miss_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      line_idx   <= '0;
      line_tag   <= '0;
      start_ofs  <= '0;
      cur_ofs    <= '0;
      beats      <= '0;
      first_pend <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (miss_ack) begin
          state      <= S_REQ;
          line_idx   <= miss_idx;
          line_tag   <= miss_tag;
          start_ofs  <= miss_ofs;
          cur_ofs    <= miss_ofs;
          beats      <= '0;
          first_pend <= 1'b1;
        end
        S_REQ:  if (mem_req_ready) state <= S_FILL;
        S_FILL: if (take) begin
          cur_ofs    <= (cur_ofs == OFS_W'(WORDS - 1)) ? '0 : cur_ofs + 1'b1;
          beats      <= beats + 1'b1;
          first_pend <= 1'b0;
          if (last) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module cwf_refill_chk #(
  parameter int WORDS  = 8,
  parameter int IDX_W  = 6,
  localparam int OFS_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_ack,
  input logic [OFS_W-1:0] miss_ofs,
  input logic             busy,
  input logic             cpu_valid,
  input logic             cpu_stall,
  input logic             arr_we,
  input logic [OFS_W-1:0] arr_ofs,
  input logic             tag_we,
  input logic             tag_valid
);

  logic [CNT_W-1:0] wr_cnt;
  logic [OFS_W-1:0] exp_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt    <= '0;
      exp_first <= '0;
    end else if (miss_ack) begin
      wr_cnt    <= '0;
      exp_first <= miss_ofs;
    end else if (arr_we) begin
      wr_cnt    <= wr_cnt + 1'b1;
    end
  end

  AST_ACK_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ack |=> busy && !miss_ack);                                         // R2
  AST_INVALIDATE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ack |-> tag_we && !tag_valid);                                      // R3
  AST_FIRST_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && wr_cnt == '0) |-> arr_ofs == exp_first);                      // R5
  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      arr_ofs == (($past(arr_ofs) == OFS_W'(WORDS - 1)) ? '0 : $past(arr_ofs) + 1'b1)); // R5
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);                                                        // R6
  AST_FORWARD_ENDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> !cpu_stall && !cpu_valid);                                 // R8
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> busy);                                                     // R8
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_we && tag_valid) |-> $past(arr_we) && wr_cnt == CNT_W'(WORDS));     // R9

endmodule

bind cwf_refill cwf_refill_chk #(.WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_ack(miss_ack), .miss_ofs(miss_ofs),
  .busy(busy), .cpu_valid(cpu_valid), .cpu_stall(cpu_stall),
  .arr_we(arr_we), .arr_ofs(arr_ofs), .tag_we(tag_we), .tag_valid(tag_valid)
);

// File: tb/tb_cwf_refill.sv
module tb_cwf_refill;
  localparam int WORDS = 8, DATA_W = 32, IDX_W = 6, TAG_W = 20, OFS_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_req = 0, mem_req_ready = 0, rd_valid = 0;
  logic [IDX_W-1:0] miss_idx = '0;
  logic [TAG_W-1:0] miss_tag = '0;
  logic [OFS_W-1:0] miss_ofs = '0;
  logic [DATA_W-1:0] rd_data = '0;
  logic miss_ack, busy, mem_req_valid, rd_ready, cpu_valid, cpu_stall, arr_we, tag_we, tag_valid;
  logic [IDX_W-1:0] mem_req_idx, arr_idx, tag_idx;
  logic [TAG_W-1:0] mem_req_tag, tag_data;
  logic [OFS_W-1:0] mem_req_ofs, arr_ofs;
  logic [DATA_W-1:0] cpu_data, arr_data;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  cwf_refill dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t, input int o);
    return {t[14:0], i, 3'(o), 8'h5A};
  endfunction

  task automatic run_fill(input logic [IDX_W-1:0] idx, input logic [TAG_W-1:0] tag, input int ofs, input int pat);
    @(negedge clk);
    miss_req = 1; miss_idx = idx; miss_tag = tag; miss_ofs = 3'(ofs);
    #1;
    chk("R2", "miss_ack idle", miss_ack, 1);
    chk("R3", "tag_we", tag_we, 1);
    chk("R3", "tag_valid", tag_valid, 0);
    chk("R3", "tag_idx", tag_idx, idx);
    @(negedge clk);
    if (pat == 2) miss_idx = idx ^ 6'h1; else miss_req = 0;
    rd_valid = 1; rd_data = 32'hDEAD_BEEF;
    for (int d = 0; d <= pat; d++) begin
      #1;
      chk("R4", "mem_req_valid", mem_req_valid, 1);
      chk("R4", "mem_req_idx", mem_req_idx, idx);
      chk("R4", "mem_req_tag", mem_req_tag, tag);
      chk("R4", "mem_req_ofs", mem_req_ofs, ofs);
      chk("R8", "cpu_stall in request", cpu_stall, 1);
      chk("R2", "miss_ack busy", miss_ack, 0);
      chk("R10", "arr_we before accept", arr_we, 0);
      chk("R6", "rd_ready before accept", rd_ready, 0);
      if (d == pat) mem_req_ready = 1;
      @(negedge clk);
    end
    mem_req_ready = 0; rd_valid = 0;
    for (int k = 0; k < WORDS; k++) begin
      int o = (ofs + k) % WORDS;
      int g = (pat == 0) ? 0 : (k + pat) % 3;
      for (int q = 0; q < g; q++) begin
        #1;
        chk("R10", "arr_we in gap", arr_we, 0);
        chk("R6", "rd_ready in fill", rd_ready, 1);
        chk("R8", "cpu_stall in gap", cpu_stall, k == 0);
        if (pat == 2) chk("R2", "miss_ack held miss", miss_ack, 0);
        @(negedge clk);
      end
      rd_valid = 1; rd_data = word(idx, tag, o);
      #1;
      chk("R6", "arr_we", arr_we, 1);
      chk("R6", "arr_idx", arr_idx, idx);
      chk("R6", "arr_data", arr_data, word(idx, tag, o));
      chk("R5", "arr_ofs", arr_ofs, o);
      chk("R7", "cpu_valid", cpu_valid, k == 0);
      if (k == 0) chk("R7", "cpu_data", cpu_data, word(idx, tag, o));
      chk("R8", "cpu_stall at beat", cpu_stall, 0);
      chk("R9", "tag_we during fill", tag_we, 0);
      @(negedge clk);
      rd_valid = 0;
    end
    #1;
    chk("R9", "tag_we end", tag_we, 1);
    chk("R9", "tag_valid end", tag_valid, 1);
    chk("R9", "tag_idx end", tag_idx, idx);
    chk("R9", "tag_data end", tag_data, tag);
    chk("R9", "busy end", busy, 1);
    if (pat == 2) chk("R2", "miss_ack last busy", miss_ack, 0);
    miss_req = 0;
    @(negedge clk);
    #1;
    chk("R9", "busy after", busy, 0);
    chk("R9", "tag_we after", tag_we, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_req_valid", mem_req_valid, 0);
    chk("R1", "rd_ready", rd_ready, 0);
    chk("R1", "arr_we", arr_we, 0);
    chk("R1", "cpu_valid", cpu_valid, 0);
    chk("R1", "cpu_stall", cpu_stall, 0);
    chk("R1", "tag_we", tag_we, 0);
    rst_n = 1;
    for (int ofs = 0; ofs < WORDS; ofs++)
      for (int pat = 0; pat < 3; pat++)
        run_fill(6'(ofs * 5 + pat), 20'h3A000 + 20'(ofs * 97 + pat * 13), ofs, pat);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule